// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

This block gathers fifteen interrupt request lines, numbered 1 to 15, and routes them to a configurable number of processors, from 1 to 16. A request line is edge-sensitive: a rising edge on line n latches bit n. The bit goes into a shared pending word, unless line n is marked for broadcast. A broadcast line sets bit n in the private force word of every processor instead.

Each processor sees the OR of the pending word and its own force word, filtered by its own mask. A global level word splits the sources into a high group and a low group. A processor's request output carries the number of the highest active source in the high group. When the high group has nothing active, it carries the highest active source in the low group. When nothing is active at all, it carries zero.

Software reaches the registers through a simple register bus that moves one 32-bit word per access. A processor retires an interrupt by pulsing its acknowledge input with the interrupt number.

The register map is a 256-byte window:

| Offset | Register |
|---|---|
| 0x00 | level word |
| 0x04 | pending word (read-only) |
| 0x08 | alias of processor 0's force word |
| 0x0C | clear word |
| 0x10 | status word |
| 0x14 | broadcast word |
| 0x40 + 4c | mask word of processor c |
| 0x80 + 4c | force word of processor c |
| 0xC0 + 4c | extension word of processor c |

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero except the status word, and every request output is zero.
- R2: A rising edge on line n (1..15) whose broadcast bit is clear sets pending bit n on that clock edge. Line 0 and lines held high set nothing further.
- R3: A processor's request output is the highest-numbered bit of ((pending | force[c]) & mask[c]) among the bits whose level bit is 1. If no such bit is active, it is the highest-numbered active bit among the level-0 bits. If nothing is active, it is 0.
- R4: A pulse on ack_valid[c] with ack_num = n clears pending bit n and force bit n of processor c, one clock later.
- R5: Writing the clear word (offset 0x0C) clears the written bits 15:1 in pending and in every processor's force word. Reads of the clear word return 0.
- R6: A write to force word c (offset 0x80 + 4c) yields (old | wdata[15:1]) & ~wdata[31:17].
- R7: Offset 0x08 reads processor 0's force word and overwrites it with wdata & 0xFFFE.
- R8: The broadcast word (offset 0x14) keeps bits 15:1. A rising edge on a broadcast line n sets force bit n of every processor and leaves pending unchanged.
- R9: Writes to the pending word (offset 0x04) have no effect.
- R10: Bit 0 reads back as 0 in the level, mask, force and broadcast words.
  - The level word keeps bits 15:1.
  - The mask words keep bits 31:1.
- R11: Extension words (offset 0xC0 + 4c) store wdata[3:0] only.
- R12: Reads of unmapped offsets return 0. So do reads of the per-processor words of processors at or above NCPU.
- R13: The status word (offset 0x10) reads as NCPU-1 in bits 31:28, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| bus_sel | input | 1 | register access strobe, one word per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | byte offset in the window (bits 1:0 ignored) |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational from address |
| irq_in | input | 16 | request lines, bit 0 unused |
| ack_valid | input | NCPU | acknowledge strobe per processor |
| ack_num | input | 4*NCPU | interrupt number per processor |
| cpu_irq | output | 4*NCPU | encoded request per processor, 0 = none |

## Verification
The assertions take three things for granted.
- A write to the pending word, with no acknowledge and no fresh edge in the same cycle, leaves pending untouched.
- Reads of the clear word are zero.
- A non-zero request code always points at a bit that the processor's mask enables.

The clear-word property assumes that no request edge arrives in the same cycle as the clear. The bench keeps to this: it drives request pulses, acknowledges and bus accesses in separate cycles, each on the falling clock edge.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  localparam int SRC_W  = 16;
  localparam int CODE_W = 4;
  localparam int MAX_CPU = 16;

  typedef logic [SRC_W-1:0] src_vec_t;

  typedef enum logic [3:0] {
    G_LEVEL = 4'd0,
    G_PEND  = 4'd1,
    G_ALIAS = 4'd2,
    G_CLEAR = 4'd3,
    G_STAT  = 4'd4,
    G_BCAST = 4'd5
  } glob_idx_e;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_MASK   = 2'd1,
    GRP_FORCE  = 2'd2,
    GRP_EXT    = 2'd3
  } grp_e;
endpackage

// File: rtl/mpic_edge.sv
module mpic_edge
  import mpic_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t lines,
  output src_vec_t rise
);
  src_vec_t prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines;
  end

  // Line 0 is never a source.
  assign rise = lines & ~prev_q & 16'hFFFE;
endmodule

// File: rtl/mpic_prio_enc.sv
module mpic_prio_enc
  import mpic_pkg::*;
(
  input  src_vec_t         active,
  input  src_vec_t         level,
  output logic [CODE_W-1:0] code
);
  src_vec_t hi, pick;

  assign hi   = active & level;
  assign pick = (hi != '0) ? hi : active;

  always_comb begin
    code = '0;
    for (int i = 1; i < SRC_W; i++)
      if (pick[i]) code = CODE_W'(i);
  end
endmodule

// File: rtl/mpic_cpu.sv
module mpic_cpu
  import mpic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask,
  input  logic              wr_force,
  input  logic              wr_alias,
  input  logic              wr_ext,
  input  logic [31:0]       wdata,
  input  src_vec_t          clr_bits,
  input  logic              ack_valid,
  input  logic [CODE_W-1:0] ack_num,
  input  src_vec_t          bc_rise,
  input  src_vec_t          pending,
  input  src_vec_t          level,
  output logic [31:0]       mask_q,
  output src_vec_t          force_q,
  output logic [3:0]        ext_q,
  output logic [CODE_W-1:0] req_code
);
  src_vec_t ack_bits, base, nxt;

  assign ack_bits = ack_valid ? (src_vec_t'(1) << ack_num) : '0;

  always_comb begin
    base = force_q;
    if (wr_force)
      base = (force_q | wdata[15:0]) & ~wdata[31:16];
    else if (wr_alias)
      base = wdata[15:0];
    nxt = ((base & ~clr_bits & ~ack_bits) | bc_rise) & 16'hFFFE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      force_q <= '0;
      ext_q   <= '0;
    end else begin
      force_q <= nxt;
      if (wr_mask) mask_q <= wdata & 32'hFFFF_FFFE;
      if (wr_ext)  ext_q  <= wdata[3:0];
    end
  end

  mpic_prio_enc u_enc (
    .active ((pending | force_q) & mask_q[15:0] & 16'hFFFE),
    .level  (level),
    .code   (req_code)
  );
endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
  import mpic_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [15:0]          irq_in,
  input  logic [NCPU-1:0]      ack_valid,
  input  logic [4*NCPU-1:0]    ack_num,
  output logic [4*NCPU-1:0]    cpu_irq
);
  localparam int SEL_W = 4;

  grp_e            grp;
  logic [SEL_W-1:0] idx;
  logic            wr;
  src_vec_t        level_q, pend_q, bcast_q, rise, clr_bits, ack_any;
  logic [31:0]     mask_arr  [NCPU];
  src_vec_t        force_arr [NCPU];
  logic [3:0]      ext_arr   [NCPU];

  assign grp = grp_e'(bus_addr[7:6]);
  assign idx = bus_addr[5:2];
  assign wr  = bus_sel && bus_we;

  mpic_edge u_edge (.clk(clk), .rst_n(rst_n), .lines(irq_in), .rise(rise));

  assign clr_bits = (wr && grp == GRP_GLOBAL && idx == G_CLEAR)
                    ? (bus_wdata[15:0] & 16'hFFFE) : '0;

  always_comb begin
    ack_any = '0;
    for (int c = 0; c < NCPU; c++)
      if (ack_valid[c]) ack_any[ack_num[c*4 +: 4]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= '0;
      pend_q  <= '0;
      bcast_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_bits & ~ack_any) | (rise & ~bcast_q);
      if (wr && grp == GRP_GLOBAL && idx == G_LEVEL) level_q <= bus_wdata[15:0] & 16'hFFFE;
      if (wr && grp == GRP_GLOBAL && idx == G_BCAST) bcast_q <= bus_wdata[15:0] & 16'hFFFE;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    mpic_cpu u_cpu (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_mask   (wr && grp == GRP_MASK  && idx == SEL_W'(c)),
      .wr_force  (wr && grp == GRP_FORCE && idx == SEL_W'(c)),
      .wr_alias  ((c == 0) && wr && grp == GRP_GLOBAL && idx == G_ALIAS),
      .wr_ext    (wr && grp == GRP_EXT   && idx == SEL_W'(c)),
      .wdata     (bus_wdata),
      .clr_bits  (clr_bits),
      .ack_valid (ack_valid[c]),
      .ack_num   (ack_num[c*4 +: 4]),
      .bc_rise   (rise & bcast_q),
      .pending   (pend_q),
      .level     (level_q),
      .mask_q    (mask_arr[c]),
      .force_q   (force_arr[c]),
      .ext_q     (ext_arr[c]),
      .req_code  (cpu_irq[c*4 +: 4])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (grp == GRP_GLOBAL) begin
      case (idx)
        G_LEVEL: bus_rdata = {16'd0, level_q};
        G_PEND:  bus_rdata = {16'd0, pend_q};
        G_ALIAS: bus_rdata = {16'd0, force_arr[0]};
        G_STAT:  bus_rdata = {4'(NCPU - 1), 28'd0};
        G_BCAST: bus_rdata = {16'd0, bcast_q};
        default: bus_rdata = '0;
      endcase
    end else begin
      for (int c = 0; c < NCPU; c++) begin
        if (idx == SEL_W'(c)) begin
          case (grp)
            GRP_MASK:  bus_rdata = mask_arr[c];
            GRP_FORCE: bus_rdata = {16'd0, force_arr[c]};
            GRP_EXT:   bus_rdata = {28'd0, ext_arr[c]};
            default:   bus_rdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mp_irq_ctrl_chk.sv
module mp_irq_ctrl_chk #(
  parameter int NCPU = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [7:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [15:0]       irq_in,
  input logic [15:0]       rise,
  input logic [NCPU-1:0]   ack_valid,
  input logic [4*NCPU-1:0] cpu_irq,
  input logic [15:0]       pend_q,
  input logic [31:0]       mask0
);
  // R9
  pend_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[7:2] == 6'd1 && ack_valid == '0 && rise == '0)
    |=> $stable(pend_q));

  // R5
  clear_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr[7:2] == 6'd3) |-> bus_rdata == 32'd0);

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr[7:2] == 6'd3 && bus_wdata[15:1] == 15'h7FFF && rise == '0)
    |=> pend_q == 16'd0);

  // R3
  code_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq[3:0] != 4'd0) |-> mask0[cpu_irq[3:0]]);
endmodule

bind mp_irq_ctrl mp_irq_ctrl_chk #(.NCPU(NCPU)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_in    (irq_in),
  .rise      (rise),
  .ack_valid (ack_valid),
  .cpu_irq   (cpu_irq),
  .pend_q    (pend_q),
  .mask0     (mask_arr[0])
);

// File: tb/mp_irq_ctrl_tb.sv
module mp_irq_ctrl_tb;
  localparam int NCPU = 4;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              bus_sel = 0, bus_we = 0;
  logic [7:0]        bus_addr = 0;
  logic [31:0]       bus_wdata = 0;
  logic [31:0]       bus_rdata;
  logic [15:0]       irq_in = 0;
  logic [NCPU-1:0]   ack_valid = 0;
  logic [4*NCPU-1:0] ack_num = 0;
  logic [4*NCPU-1:0] cpu_irq;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mp_irq_ctrl #(.NCPU(NCPU)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 check(req, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic pulse(int n);
    @(negedge clk); irq_in[n] = 1;
    @(negedge clk); irq_in[n] = 0;
  endtask

  task automatic ack(int c, int n);
    @(negedge clk); ack_valid[c] = 1; ack_num[c*4 +: 4] = 4'(n);
    @(negedge clk); ack_valid[c] = 0;
  endtask

  task automatic irq_chk(string req, int c, int exp);
    @(negedge clk);
    #1 check(req, 32'(cpu_irq[c*4 +: 4]), 32'(exp));
  endtask

  task automatic t_reset;
    rd_chk("R1 level", 8'h00, 0);
    rd_chk("R1 pend", 8'h04, 0);
    rd_chk("R1 mask0", 8'h40, 0);
    rd_chk("R1 force2", 8'h88, 0);
    check("R1 irq", 32'(cpu_irq), 0);
  endtask

  task automatic t_pending;
    pulse(5);
    rd_chk("R2 pend set", 8'h04, 32'h20);
    irq_chk("R3 masked off", 0, 0);
    wr(8'h40, 32'h0000_0221);
    rd_chk("R10 mask bit0", 8'h40, 32'h220);
    irq_chk("R3 single", 0, 5);
    irq_chk("R3 cpu1 unmasked", 1, 0);
    pulse(0);
    rd_chk("R2 line0", 8'h04, 32'h20);
  endtask

  task automatic t_prio;
    pulse(9);
    irq_chk("R3 highest", 0, 9);
    wr(8'h00, 32'h0000_0021);
    rd_chk("R10 level bit0", 8'h00, 32'h20);
    irq_chk("R3 level1 wins", 0, 5);
  endtask

  task automatic t_ack;
    ack(0, 5);
    rd_chk("R4 pend after ack", 8'h04, 32'h200);
    irq_chk("R4 next", 0, 9);
  endtask

  task automatic t_clear;
    wr(8'h0C, 32'h0000_FFFF);
    rd_chk("R5 pend cleared", 8'h04, 0);
    rd_chk("R5 clear reads 0", 8'h0C, 0);
    irq_chk("R5 no irq", 0, 0);
  endtask

  task automatic t_force;
    wr(8'h84, 32'h0000_0015);
    rd_chk("R6 set", 8'h84, 32'h14);
    wr(8'h84, 32'h0004_0100);
    rd_chk("R6 set+clear", 8'h84, 32'h110);
    wr(8'h08, 32'h0001_8003);
    rd_chk("R7 alias", 8'h80, 32'h8002);
    rd_chk("R7 alias read", 8'h08, 32'h8002);
    wr(8'h44, 32'h0000_0100);
    irq_chk("R3 force feeds", 1, 8);
  endtask

  task automatic t_bcast;
    wr(8'h0C, 32'h0000_FFFF);
    wr(8'h14, 32'h0000_0041);
    rd_chk("R8 bcast bits", 8'h14, 32'h40);
    pulse(6);
    rd_chk("R8 pend untouched", 8'h04, 0);
    rd_chk("R8 force0", 8'h80, 32'h40);
    rd_chk("R8 force3", 8'h8C, 32'h40);
    ack(3, 6);
    rd_chk("R4 force3 ack", 8'h8C, 0);
    rd_chk("R4 force0 kept", 8'h80, 32'h40);
  endtask

  task automatic t_misc;
    pulse(3);
    wr(8'h04, 32'h0000_0000);
    rd_chk("R9 pend ro", 8'h04, 32'h8);
    wr(8'hC4, 32'hFFFF_FFFF);
    rd_chk("R11 ext", 8'hC4, 32'hF);
    rd_chk("R12 unmapped", 8'h20, 0);
    rd_chk("R12 cpu beyond", 8'h50, 0);
    rd_chk("R13 status", 8'h10, 32'h3000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pending();
    t_prio();
    t_ack();
    t_clear();
    t_force();
    t_bcast();
    t_misc();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule